// File: doc/BRIEF.md
# Multi-Cycle Integer Divider with Condition Codes

This block is the division unit of a CPU execution stage. It takes a dividend, a divisor, a form selector and a signedness bit together with a start pulse. It then produces a quotient, a remainder and an updated five-bit condition code. It works out one quotient bit per clock with a restoring shift-and-subtract step. It does this on operand magnitudes, and the signs are applied only after the last step.

Three forms are supported. In the word form, a 32-bit dividend is divided by the low 16 bits of the divisor, and the result is packed with the remainder in the upper half and the quotient in the lower half. In the long form, a 32-bit dividend is divided by a 32-bit divisor. In the wide form, the dividend is the 64-bit concatenation of a high and a low word, divided by a 32-bit divisor.

A zero divisor raises a trap request with vector 5, and no result is written. A quotient that does not fit its destination sets V and suppresses the write. The caller owns writeback: it stores the results only when the write flag is set during the done pulse.

Top module: `div_iter_unit`

## Requirements
- R1: Word form (form_i = 0) divides the 32-bit dvd_lo_i by dvs_i[15:0]. Signed division truncates toward zero, and the remainder takes the sign of the dividend. quot_o carries the remainder in bits 31:16 and the quotient in bits 15:0. rem_o carries the remainder extended to 32 bits, and dvs_i[31:16] has no effect.
- R2: Long form (form_i = 1) divides the 32-bit dvd_lo_i by the 32-bit dvs_i, with the same signed rules. quot_o is the 32-bit quotient and rem_o the 32-bit remainder.
- R3: Wide form (form_i = 2, and form_i = 3 behaves identically) divides the 64-bit value {dvd_hi_i, dvd_lo_i} by dvs_i, giving a 32-bit quotient and remainder.
- R4: A divisor of zero (dvs_i[15:0] in word form, dvs_i otherwise) completes with trap_o = 1, trap_vec_o = 5, wr_o = 0, ovf_o = 0, quot_o = rem_o = 0 and ccr_o equal to ccr_i, with done_o high after the rising edge that samples start.
- R5: When the quotient exceeds the destination range, the block completes with ovf_o = 1, wr_o = 0, quot_o = rem_o = 0 and flags Z = 0, V = 1, C = 0. The condition code layout is bit 4 X, bit 3 N, bit 2 Z, bit 1 V, bit 0 C.
- R6: On overflow, N equals the top dividend bit XOR signed_i. The top dividend bit is dvd_hi_i[31] in wide form and dvd_lo_i[31] otherwise.
- R7: Without overflow or trap, wr_o = 1. N is the quotient sign bit (bit 15 in word form, bit 31 otherwise), Z is set when the quotient is zero, and V and C are cleared.
- R8: X in ccr_o always equals X in the ccr_i value sampled with start.
- R9: done_o is a one-cycle pulse raised one cycle after the final quotient step. It first appears after rising edge DW+2, counting the edge that samples start as edge 1, for 32-bit dividends, and after edge 2*DW+2 for the wide form. busy_o is high while stepping.
- R10: A start pulse while busy_o is high is ignored: the running division and its result are unchanged and no extra completion follows.
- R11: Signed ranges are exact. A quotient of -2^15 (word) or -2^31 (long/wide) fits, while +2^15 or +2^31 overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, sampled while idle |
| form_i | input | 2 | 0 word, 1 long, 2/3 wide dividend |
| signed_i | input | 1 | Two's-complement operation |
| dvd_hi_i | input | DW | Upper dividend word (wide form) |
| dvd_lo_i | input | DW | Lower dividend word |
| dvs_i | input | DW | Divisor |
| ccr_i | input | 5 | Incoming X N Z V C |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | Completion pulse |
| wr_o | output | 1 | Results may be written back |
| ovf_o | output | 1 | Quotient overflow |
| trap_o | output | 1 | Divide-by-zero trap request |
| trap_vec_o | output | 8 | Trap vector number |
| quot_o | output | DW | Quotient, or packed remainder:quotient in word form |
| rem_o | output | DW | Remainder |
| ccr_o | output | 5 | Updated X N Z V C |

## Verification
The bench targets the signed range edges, where a design with an off-by-one limit would either reject -32768 or -2^31, or else accept +32768 or +2^31 and write a wrapped quotient. It drives the two wide-form overflow cases whose only difference is the top dividend bit. A design that took N from the quotient or from a constant would give the same N for both. Other cases cover a zero divisor hidden under nonzero upper bits in word form, which a design testing all 32 bits would miss, and mixed-sign operands, where a wrong remainder sign shows up in the packed upper half. A start pulse during a running division checks that the result and completion count are not disturbed.

// File: rtl/div_iter_pkg.sv
package div_iter_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } state_e;

    typedef enum logic [1:0] {
        FORM_WORD     = 2'd0,
        FORM_LONG     = 2'd1,
        FORM_WIDE     = 2'd2,
        FORM_WIDE_ALT = 2'd3
    } form_e;

    localparam int CCR_X = 4;
    localparam int CCR_N = 3;
    localparam int CCR_Z = 2;
    localparam int CCR_V = 1;
    localparam int CCR_C = 0;

    localparam logic [7:0] VEC_ZERO_DIV = 8'd5;

endpackage

// File: rtl/div_iter_prep.sv
module div_iter_prep
    import div_iter_pkg::*;
#(
    parameter int DW = 32
) (
    input  form_e                     form_i,
    input  logic                      sgn_i,
    input  logic [DW-1:0]             hi_i,
    input  logic [DW-1:0]             lo_i,
    input  logic [DW-1:0]             dvs_i,
    output logic [2*DW-1:0]           quo_init_o,
    output logic [DW-1:0]             den_o,
    output logic                      num_neg_o,
    output logic                      den_neg_o,
    output logic                      n_src_o,
    output logic                      zero_o,
    output logic [$clog2(2*DW+1)-1:0] steps_o
);
    localparam int QW = 2 * DW;
    localparam int HW = DW / 2;
    localparam int CW = $clog2(QW + 1);

    logic          wide;
    logic          word;
    logic [QW-1:0] num_full;
    logic [QW-1:0] num_mag;
    logic [DW-1:0] den_full;

    always_comb begin
        wide      = (form_i == FORM_WIDE) || (form_i == FORM_WIDE_ALT);
        word      = (form_i == FORM_WORD);
        num_full  = wide ? {hi_i, lo_i} : {{DW{sgn_i & lo_i[DW-1]}}, lo_i};
        num_neg_o = sgn_i & num_full[QW-1];
        num_mag   = num_neg_o ? (~num_full + {{(QW-1){1'b0}}, 1'b1}) : num_full;
        den_full  = word ? {{HW{sgn_i & dvs_i[HW-1]}}, dvs_i[HW-1:0]} : dvs_i;
        den_neg_o = sgn_i & den_full[DW-1];
        den_o     = den_neg_o ? (~den_full + {{(DW-1){1'b0}}, 1'b1}) : den_full;
        zero_o    = (den_full == '0);
        n_src_o   = wide ? hi_i[DW-1] : lo_i[DW-1];
        // Short dividends start at the top so DW shifts consume them fully.
        quo_init_o = wide ? num_mag : {num_mag[DW-1:0], {DW{1'b0}}};
        steps_o    = wide ? CW'(QW) : CW'(DW);
    end

endmodule

// File: rtl/div_iter_step.sv
module div_iter_step #(
    parameter int DW = 32
) (
    input  logic [DW-1:0]   rem_i,
    input  logic [2*DW-1:0] quo_i,
    input  logic [DW-1:0]   den_i,
    output logic [DW-1:0]   rem_o,
    output logic [2*DW-1:0] quo_o
);
    localparam int QW = 2 * DW;

    logic [DW:0] trial;
    logic [DW:0] diff;

    always_comb begin
        trial = {rem_i, quo_i[QW-1]};
        diff  = trial - {1'b0, den_i};
        quo_o = {quo_i[QW-2:0], 1'b0};
        if (trial >= {1'b0, den_i}) begin
            rem_o    = diff[DW-1:0];
            quo_o[0] = 1'b1;
        end else begin
            rem_o = trial[DW-1:0];
        end
    end

endmodule

// File: rtl/div_iter_post.sv
module div_iter_post
    import div_iter_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [2*DW-1:0] quo_i,
    input  logic [DW-1:0]   rem_i,
    input  form_e           form_i,
    input  logic            sgn_i,
    input  logic            num_neg_i,
    input  logic            den_neg_i,
    input  logic            n_src_i,
    input  logic [4:0]      ccr_i,
    output logic [DW-1:0]   quot_o,
    output logic [DW-1:0]   rem_o,
    output logic            ovf_o,
    output logic [4:0]      ccr_o
);
    localparam int QW = 2 * DW;
    localparam int HW = DW / 2;
    localparam logic [QW-1:0] ONE = {{(QW-1){1'b0}}, 1'b1};

    logic          word;
    logic          q_neg;
    logic          r_neg;
    int            w;
    logic [QW-1:0] lim;
    logic [DW-1:0] q_sgn;
    logic [DW-1:0] r_sgn;

    always_comb begin
        word  = (form_i == FORM_WORD);
        q_neg = sgn_i & (num_neg_i ^ den_neg_i);
        r_neg = sgn_i & num_neg_i;
        w     = word ? HW : DW;
        if (!sgn_i) begin
            lim = (ONE << w) - ONE;
        end else if (q_neg) begin
            lim = ONE << (w - 1);
        end else begin
            lim = (ONE << (w - 1)) - ONE;
        end
        ovf_o = (quo_i > lim);
        q_sgn = q_neg ? (~quo_i[DW-1:0] + {{(DW-1){1'b0}}, 1'b1}) : quo_i[DW-1:0];
        r_sgn = r_neg ? (~rem_i + {{(DW-1){1'b0}}, 1'b1}) : rem_i;

        ccr_o = ccr_i;
        if (ovf_o) begin
            quot_o       = '0;
            rem_o        = '0;
            ccr_o[CCR_N] = n_src_i ^ sgn_i;
            ccr_o[CCR_Z] = 1'b0;
            ccr_o[CCR_V] = 1'b1;
            ccr_o[CCR_C] = 1'b0;
        end else begin
            rem_o = r_sgn;
            if (word) begin
                quot_o       = {r_sgn[HW-1:0], q_sgn[HW-1:0]};
                ccr_o[CCR_N] = q_sgn[HW-1];
                ccr_o[CCR_Z] = (q_sgn[HW-1:0] == '0);
            end else begin
                quot_o       = q_sgn;
                ccr_o[CCR_N] = q_sgn[DW-1];
                ccr_o[CCR_Z] = (q_sgn == '0);
            end
            ccr_o[CCR_V] = 1'b0;
            ccr_o[CCR_C] = 1'b0;
        end
    end

endmodule

// File: rtl/div_iter_unit.sv
module div_iter_unit
    import div_iter_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [1:0]    form_i,
    input  logic          signed_i,
    input  logic [DW-1:0] dvd_hi_i,
    input  logic [DW-1:0] dvd_lo_i,
    input  logic [DW-1:0] dvs_i,
    input  logic [4:0]    ccr_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          wr_o,
    output logic          ovf_o,
    output logic          trap_o,
    output logic [7:0]    trap_vec_o,
    output logic [DW-1:0] quot_o,
    output logic [DW-1:0] rem_o,
    output logic [4:0]    ccr_o
);
    localparam int QW = 2 * DW;
    localparam int CW = $clog2(QW + 1);

    typedef struct packed {
        state_e        st;
        logic [CW-1:0] cnt;
        logic [DW-1:0] rem;
        logic [QW-1:0] quo;
        logic [DW-1:0] den;
        form_e         form;
        logic          sgn;
        logic          num_neg;
        logic          den_neg;
        logic          n_src;
        logic [4:0]    ccr_in;
        logic          done;
        logic          wr;
        logic          ovf;
        logic          trap;
        logic [DW-1:0] q_res;
        logic [DW-1:0] r_res;
        logic [4:0]    ccr_res;
    } regs_t;

    regs_t r_d, r_q;

    logic [QW-1:0] p_quo;
    logic [DW-1:0] p_den;
    logic          p_num_neg, p_den_neg, p_n_src, p_zero;
    logic [CW-1:0] p_steps;
    logic [DW-1:0] s_rem;
    logic [QW-1:0] s_quo;
    logic [DW-1:0] f_quot, f_rem;
    logic          f_ovf;
    logic [4:0]    f_ccr;

    div_iter_prep #(.DW(DW)) u_prep (
        .form_i     (form_e'(form_i)),
        .sgn_i      (signed_i),
        .hi_i       (dvd_hi_i),
        .lo_i       (dvd_lo_i),
        .dvs_i      (dvs_i),
        .quo_init_o (p_quo),
        .den_o      (p_den),
        .num_neg_o  (p_num_neg),
        .den_neg_o  (p_den_neg),
        .n_src_o    (p_n_src),
        .zero_o     (p_zero),
        .steps_o    (p_steps)
    );

    div_iter_step #(.DW(DW)) u_step (
        .rem_i (r_q.rem),
        .quo_i (r_q.quo),
        .den_i (r_q.den),
        .rem_o (s_rem),
        .quo_o (s_quo)
    );

    div_iter_post #(.DW(DW)) u_post (
        .quo_i     (r_q.quo),
        .rem_i     (r_q.rem),
        .form_i    (r_q.form),
        .sgn_i     (r_q.sgn),
        .num_neg_i (r_q.num_neg),
        .den_neg_i (r_q.den_neg),
        .n_src_i   (r_q.n_src),
        .ccr_i     (r_q.ccr_in),
        .quot_o    (f_quot),
        .rem_o     (f_rem),
        .ovf_o     (f_ovf),
        .ccr_o     (f_ccr)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (p_zero) begin
                        r_d.done    = 1'b1;
                        r_d.trap    = 1'b1;
                        r_d.wr      = 1'b0;
                        r_d.ovf     = 1'b0;
                        r_d.q_res   = '0;
                        r_d.r_res   = '0;
                        r_d.ccr_res = ccr_i;
                    end else begin
                        r_d.st      = ST_RUN;
                        r_d.cnt     = p_steps;
                        r_d.rem     = '0;
                        r_d.quo     = p_quo;
                        r_d.den     = p_den;
                        r_d.form    = form_e'(form_i);
                        r_d.sgn     = signed_i;
                        r_d.num_neg = p_num_neg;
                        r_d.den_neg = p_den_neg;
                        r_d.n_src   = p_n_src;
                        r_d.ccr_in  = ccr_i;
                    end
                end
            end
            ST_RUN: begin
                r_d.rem = s_rem;
                r_d.quo = s_quo;
                r_d.cnt = r_q.cnt - 1'b1;
                if (r_q.cnt == CW'(1)) begin
                    r_d.st = ST_FIN;
                end
            end
            ST_FIN: begin
                r_d.st      = ST_IDLE;
                r_d.done    = 1'b1;
                r_d.trap    = 1'b0;
                r_d.ovf     = f_ovf;
                r_d.wr      = !f_ovf;
                r_d.q_res   = f_quot;
                r_d.r_res   = f_rem;
                r_d.ccr_res = f_ccr;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o     = (r_q.st != ST_IDLE);
    assign done_o     = r_q.done;
    assign wr_o       = r_q.wr;
    assign ovf_o      = r_q.ovf;
    assign trap_o     = r_q.trap;
    assign trap_vec_o = r_q.trap ? VEC_ZERO_DIV : 8'd0;
    assign quot_o     = r_q.q_res;
    assign rem_o      = r_q.r_res;
    assign ccr_o      = r_q.ccr_res;

endmodule

// File: rtl/div_iter_unit_chk.sv
module div_iter_unit_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic [4:0]    ccr_i,
    input logic          busy_o,
    input logic          done_o,
    input logic          wr_o,
    input logic          ovf_o,
    input logic          trap_o,
    input logic [7:0]    trap_vec_o,
    input logic [DW-1:0] quot_o,
    input logic [DW-1:0] rem_o,
    input logic [4:0]    ccr_o
);
    logic x_hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_hold_q <= 1'b0;
        end else if (start_i && !busy_o) begin
            x_hold_q <= ccr_i[4];
        end
    end

    a_r4_trap_vector: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && trap_o) |-> (trap_vec_o == 8'd5 && !wr_o && !ovf_o));

    a_r5_overflow_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ovf_o) |-> (ccr_o[2:0] == 3'b010 && !wr_o && quot_o == '0 && rem_o == '0));

    a_r7_clean_vc: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && wr_o) |-> (ccr_o[1:0] == 2'b00 && !trap_o));

    a_r8_x_kept: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (ccr_o[4] == x_hold_q));

    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    a_r9_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !trap_o) |-> $past(busy_o));

endmodule

bind div_iter_unit div_iter_unit_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .ccr_i      (ccr_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .wr_o       (wr_o),
    .ovf_o      (ovf_o),
    .trap_o     (trap_o),
    .trap_vec_o (trap_vec_o),
    .quot_o     (quot_o),
    .rem_o      (rem_o),
    .ccr_o      (ccr_o)
);

// File: tb/div_iter_unit_tb.sv
`timescale 1ns/1ps
module div_iter_unit_tb;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [1:0]    form_i = 2'd0;
    logic          signed_i = 1'b0;
    logic [DW-1:0] dvd_hi_i = '0;
    logic [DW-1:0] dvd_lo_i = '0;
    logic [DW-1:0] dvs_i = '0;
    logic [4:0]    ccr_i = '0;
    logic          busy_o, done_o, wr_o, ovf_o, trap_o;
    logic [7:0]    trap_vec_o;
    logic [DW-1:0] quot_o, rem_o;
    logic [4:0]    ccr_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    div_iter_unit #(.DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .form_i(form_i),
        .signed_i(signed_i), .dvd_hi_i(dvd_hi_i), .dvd_lo_i(dvd_lo_i),
        .dvs_i(dvs_i), .ccr_i(ccr_i), .busy_o(busy_o), .done_o(done_o),
        .wr_o(wr_o), .ovf_o(ovf_o), .trap_o(trap_o), .trap_vec_o(trap_vec_o),
        .quot_o(quot_o), .rem_o(rem_o), .ccr_o(ccr_o)
    );

    typedef struct packed {
        logic [1:0]  form;
        logic        sgn;
        logic [31:0] hi;
        logic [31:0] lo;
        logic [31:0] dvs;
        logic [4:0]  ccr;
        logic [31:0] eq;
        logic [31:0] er;
        logic [4:0]  eccr;
        logic        eovf;
        logic        etrap;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 21;
    // ccr bits: 4 X, 3 N, 2 Z, 1 V, 0 C
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 32'h0, 32'd100,       32'd7,       5'h1F, 32'h0002000E, 32'h2,        5'h10, 1'b0, 1'b0, 8'd1},  // R1 unsigned word, X kept
        '{2'd0, 1'b1, 32'h0, 32'hFFFFFF9C,  32'd7,       5'h00, 32'hFFFEFFF2, 32'hFFFFFFFE, 5'h08, 1'b0, 1'b0, 8'd1},  // R1 -100/7
        '{2'd0, 1'b1, 32'h0, 32'd100,       32'hABCDFFF9,5'h00, 32'h0002FFF2, 32'h2,        5'h08, 1'b0, 1'b0, 8'd1},  // R1 100/-7, upper divisor ignored
        '{2'd0, 1'b0, 32'h0, 32'h00100000,  32'h10,      5'h00, 32'h0,        32'h0,        5'h02, 1'b1, 1'b0, 8'd5},  // R5 word overflow
        '{2'd0, 1'b1, 32'h0, 32'hFFFF8000,  32'd1,       5'h00, 32'h00008000, 32'h0,        5'h08, 1'b0, 1'b0, 8'd11}, // R11 -32768 fits
        '{2'd0, 1'b1, 32'h0, 32'h00008000,  32'd1,       5'h00, 32'h0,        32'h0,        5'h0A, 1'b1, 1'b0, 8'd11}, // R11 +32768 overflows, R6 N
        '{2'd0, 1'b0, 32'h0, 32'd5,         32'd9,       5'h00, 32'h00050000, 32'h5,        5'h04, 1'b0, 1'b0, 8'd7},  // R7 zero quotient
        '{2'd0, 1'b0, 32'h0, 32'd123,       32'h00010000,5'h15, 32'h0,        32'h0,        5'h15, 1'b0, 1'b1, 8'd4},  // R4 word zero divisor
        '{2'd1, 1'b1, 32'h0, 32'h80008080,  32'h10,      5'h00, 32'hF8000808, 32'h0,        5'h08, 1'b0, 1'b0, 8'd2},  // R2 negative long
        '{2'd1, 1'b0, 32'h0, 32'hFFFFFFFF,  32'h10,      5'h00, 32'h0FFFFFFF, 32'hF,        5'h00, 1'b0, 1'b0, 8'd2},  // R2 unsigned long
        '{2'd1, 1'b1, 32'h0, 32'hFFFFFF9C,  32'hFFFFFFF9,5'h00, 32'hE,        32'hFFFFFFFE, 5'h00, 1'b0, 1'b0, 8'd2},  // R2 neg/neg
        '{2'd2, 1'b0, 32'h10, 32'h7FFF7FFF, 32'h10,      5'h00, 32'h0,        32'h0,        5'h02, 1'b1, 1'b0, 8'd6},  // R6 N=0
        '{2'd2, 1'b0, 32'hFFFF0000, 32'hAAAAAAAA, 32'h10,5'h00, 32'h0,        32'h0,        5'h0A, 1'b1, 1'b0, 8'd6},  // R6 N=1
        '{2'd2, 1'b0, 32'h1, 32'h0,         32'h10,      5'h00, 32'h10000000, 32'h0,        5'h00, 1'b0, 1'b0, 8'd3},  // R3 wide fits
        '{2'd2, 1'b1, 32'hFFFFFFFF, 32'hFFFFFF9C, 32'd7, 5'h00, 32'hFFFFFFF2, 32'hFFFFFFFE, 5'h08, 1'b0, 1'b0, 8'd3},  // R3 signed wide
        '{2'd2, 1'b1, 32'hFFFFFFFF, 32'h80000000, 32'd1, 5'h00, 32'h80000000, 32'h0,        5'h08, 1'b0, 1'b0, 8'd11}, // R11 -2^31 fits
        '{2'd1, 1'b1, 32'h0, 32'd55,        32'h0,       5'h0A, 32'h0,        32'h0,        5'h0A, 1'b0, 1'b1, 8'd4},  // R4 long zero divisor
        '{2'd2, 1'b1, 32'h0, 32'h80000000,  32'd1,       5'h00, 32'h0,        32'h0,        5'h0A, 1'b1, 1'b0, 8'd11}, // R11 +2^31 overflows
        '{2'd2, 1'b0, 32'h10, 32'h7FFF7FFF, 32'h10,      5'h1F, 32'h0,        32'h0,        5'h12, 1'b1, 1'b0, 8'd8},  // R8 X kept on overflow
        '{2'd1, 1'b0, 32'h0, 32'd3,         32'hFFFFFFFF,5'h0E, 32'h0,        32'h3,        5'h04, 1'b0, 1'b0, 8'd7},  // R7 Z set, N cleared
        '{2'd3, 1'b0, 32'h0, 32'd100,       32'd7,       5'h00, 32'hE,        32'h2,        5'h00, 1'b0, 1'b0, 8'd3}   // R3 code 3 as wide
    };

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_div(input logic [1:0] f, input logic s, input logic [31:0] h,
                           input logic [31:0] l, input logic [31:0] d, input logic [4:0] c,
                           output int lat);
        @(negedge clk);
        form_i = f; signed_i = s; dvd_hi_i = h; dvd_lo_i = l; dvs_i = d; ccr_i = c;
        start_i = 1'b1;
        @(posedge clk);
        lat = 1;
        @(negedge clk);
        start_i = 1'b0;
        while (!done_o && lat < 300) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        int lat;
        int exp_lat;
        string rq;
        repeat (3) @(negedge clk);
        // reset state
        check("R9", "reset busy", 64'(busy_o), 64'd0);
        check("R9", "reset done", 64'(done_o), 64'd0);
        check("R4", "reset trap", 64'(trap_o), 64'd0);
        check("R7", "reset wr", 64'(wr_o), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            rq = $sformatf("R%0d", v.req);
            run_div(v.form, v.sgn, v.hi, v.lo, v.dvs, v.ccr, lat);
            exp_lat = v.etrap ? 1 : ((v.form[1]) ? 2 * DW + 2 : DW + 2);
            check("R9", $sformatf("latency v%0d", i), 64'(lat), 64'(exp_lat));
            check(rq, $sformatf("quot v%0d", i), 64'(quot_o), 64'(v.eq));
            check(rq, $sformatf("rem v%0d", i), 64'(rem_o), 64'(v.er));
            check(rq, $sformatf("ccr v%0d", i), 64'(ccr_o), 64'(v.eccr));
            check(rq, $sformatf("ovf v%0d", i), 64'(ovf_o), 64'(v.eovf));
            check(rq, $sformatf("trap v%0d", i), 64'(trap_o), 64'(v.etrap));
            check(rq, $sformatf("wr v%0d", i), 64'(wr_o), 64'(!v.eovf && !v.etrap));
            check(rq, $sformatf("vec v%0d", i), 64'(trap_vec_o), v.etrap ? 64'd5 : 64'd0);
            @(negedge clk);
            check("R9", $sformatf("done pulse v%0d", i), 64'(done_o), 64'd0);
        end

        // R10: start while busy is ignored
        @(negedge clk);
        form_i = 2'd0; signed_i = 1'b0; dvd_hi_i = '0; dvd_lo_i = 32'd100; dvs_i = 32'd7; ccr_i = 5'h00;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R9", "busy while stepping", 64'(busy_o), 64'd1);
        repeat (4) @(negedge clk);
        form_i = 2'd2; dvd_hi_i = 32'h1; dvd_lo_i = 32'h0; dvs_i = 32'd3; ccr_i = 5'h1F;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 6;
        while (!done_o && lat < 300) begin
            @(negedge clk);
            lat++;
        end
        check("R10", "latency unchanged", 64'(lat), 64'(DW + 2));
        check("R10", "first result kept", 64'(quot_o), 64'h0002000E);
        check("R10", "first ccr kept", 64'(ccr_o), 64'h00);
        begin
            int extra;
            extra = 0;
            for (int k = 0; k < 80; k++) begin
                @(negedge clk);
                if (done_o) extra++;
            end
            check("R10", "no extra completion", 64'(extra), 64'd0);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule